// File: doc/BRIEF.md
# Receiver Error Logger and Sample Concealment

This block sits behind a digital audio receiver front end. For each received sample it takes a set of seven error flags: validity, parity, biphase, confidence, PLL lock, Q-subcode CRC and channel-status CRC. A per-bit enable register decides which flags count. Flags that count are recorded in a sticky status register, which software clears by reading it. They also raise a one-cycle interrupt pulse and drive two level error outputs. One output covers every counted error. The other covers every counted error except validity.

The same counted errors, apart from the two CRC flags, drive a concealment stage on the sample path. A two-bit policy field chooses how a flagged sample is handled. The stage can repeat the last clean sample, send zero, or let the sample through untouched. Software reaches the enable mask, the status register and the policy field over a simple register bus with registered read data. Each sample strobe marks one subframe boundary.

Top module: `rx_err_logger`

## Requirements
- R1: After reset the enable mask, status and policy registers read 0, and `out_valid`, `out_data`, `irq`, `rerr` and `nverr` are 0.
- R2: Register addresses are: 0 for the enable mask (read/write, bits 6:0), 1 for status (read-only, clears on read) and 2 for the policy field (read/write, bits 1:0). Unused bits read as 0, so bit 7 of the mask always reads 0. Read data appears on `reg_rdata` one cycle after `reg_rd`.
- R3: Error bit order in the mask and status registers is: bit0 validity, bit1 parity, bit2 biphase, bit3 confidence, bit4 PLL lock, bit5 Q-subcode CRC, bit6 channel-status CRC. A status bit sets on a sample whose flag is enabled (mask bit 1) and stays set across later samples. It stays set until a read of address 1 returns it, and that read clears it.
- R4: A flag whose mask bit is 0 is not logged, raises no `irq`, does not assert `rerr` or `nverr`, and does not change the sample.
- R5: `irq` is high for exactly the cycle after a sample strobe that carries at least one enabled flag, and is low otherwise.
- R6: `rerr` is updated at each sample strobe, to 1 if that sample has any enabled flag and to 0 otherwise. It holds its value between strobes and is unaffected by status reads.
- R7: `nverr` follows `rerr`, except that an enabled validity flag (bit0) alone does not assert it.
- R8: With policy 2'b00, a sample carrying an enabled flag in bits 4:0 is replaced by the most recent sample that carried no such flag. Before any clean sample, that replacement is 0.
- R9: With policy 2'b01, a sample carrying an enabled flag in bits 4:0 is replaced by zero.
- R10: With policy 2'b10 or 2'b11, the sample always passes unchanged.
- R11: The CRC flags (bits 5 and 6) never alter the sample under any policy, but they are logged and raise `irq`, `rerr` and `nverr`.
- R12: If a status read and a sample strobe with an enabled flag fall in the same cycle, the read returns the old status and the new flag remains set afterwards.
- R13: `out_valid` rises exactly one cycle after `smp_valid`, with the processed sample on `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe, one per subframe |
| smp_data | input | DATA_W | Incoming audio sample |
| err_flags | input | 7 | Error flags of the current sample |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| out_valid | output | 1 | Processed sample strobe |
| out_data | output | DATA_W | Processed audio sample |
| irq | output | 1 | Error interrupt pulse |
| rerr | output | 1 | Level error, all enabled flags |
| nverr | output | 1 | Level error, enabled flags except validity |

## Verification
The bench builds the block with its default 24-bit sample width. That width gives each table entry a distinct sample word, so a repeated, zeroed or passed sample is never confused with another. The fixed seven-flag width lets every flag, each mask position and both CRC exclusions be driven one at a time. All four policy codes are driven, including the unused 2'b11. Status reads are placed between strobes, back to back, and in the same cycle as a strobe.

// File: rtl/rxel_pkg.sv
package rxel_pkg;

    localparam int NERR   = 7;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_HOLD = 2'd2;

    localparam int B_VALIDITY = 0;
    localparam int B_PARITY   = 1;
    localparam int B_BIPHASE  = 2;
    localparam int B_CONF     = 3;
    localparam int B_LOCK     = 4;
    localparam int B_QCRC     = 5;
    localparam int B_CSCRC    = 6;

    localparam logic [NERR-1:0] SAMPLE_AFFECT = 7'b001_1111;
    localparam logic [NERR-1:0] NO_VALIDITY   = 7'b111_1110;

    typedef enum logic [1:0] {
        HOLD_REPEAT = 2'b00,
        HOLD_MUTE   = 2'b01,
        HOLD_PASS   = 2'b10,
        HOLD_PASS_X = 2'b11
    } hold_e;

    typedef struct packed {
        logic            strobe;
        logic [NERR-1:0] live;
    } err_ev_t;

    function automatic logic needs_conceal(input logic [NERR-1:0] live);
        return |(live & SAMPLE_AFFECT);
    endfunction

    function automatic logic any_nonvalid(input logic [NERR-1:0] live);
        return |(live & NO_VALIDITY);
    endfunction

endpackage

// File: rtl/rxel_regs.sv
module rxel_regs
    import rxel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    input  err_ev_t           ev,
    output logic [NERR-1:0]   mask_q,
    output hold_e             hold_q,
    output logic [NERR-1:0]   status_q,
    output logic [REG_W-1:0]  reg_rdata
);

    logic stat_rd;
    logic unused_wbit;

    assign stat_rd     = reg_rd && (reg_addr == ADDR_STAT);
    assign unused_wbit = reg_wdata[REG_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            hold_q <= HOLD_REPEAT;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_MASK) mask_q <= reg_wdata[NERR-1:0];
            if (reg_addr == ADDR_HOLD) hold_q <= hold_e'(reg_wdata[1:0]);
        end
    end

    for (genvar i = 0; i < NERR; i++) begin : g_sticky
        logic hit;
        assign hit = ev.strobe && ev.live[i];
        always_ff @(posedge clk) begin
            if (rst)          status_q[i] <= 1'b0;
            else if (hit)     status_q[i] <= 1'b1;
            else if (stat_rd) status_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (reg_addr)
                ADDR_MASK: reg_rdata <= {1'b0, mask_q};
                ADDR_STAT: reg_rdata <= {1'b0, status_q};
                ADDR_HOLD: reg_rdata <= {6'b0, hold_q};
                default:   reg_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/rxel_level.sv
module rxel_level
    import rxel_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  err_ev_t ev,
    output logic    irq,
    output logic    rerr,
    output logic    nverr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq   <= 1'b0;
            rerr  <= 1'b0;
            nverr <= 1'b0;
        end else begin
            irq <= ev.strobe && (|ev.live);
            if (ev.strobe) begin
                rerr  <= |ev.live;
                nverr <= any_nonvalid(ev.live);
            end
        end
    end

endmodule

// File: rtl/rxel_conceal.sv
module rxel_conceal
    import rxel_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  err_ev_t           ev,
    input  logic [DATA_W-1:0] smp_data,
    input  hold_e             hold_q,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic              bad;
    logic [DATA_W-1:0] last_good;
    logic [DATA_W-1:0] chosen;

    assign bad = needs_conceal(ev.live);

    always_comb begin
        chosen = smp_data;
        if (bad) begin
            case (hold_q)
                HOLD_REPEAT: chosen = last_good;
                HOLD_MUTE:   chosen = '0;
                default:     chosen = smp_data;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            last_good <= '0;
        end else begin
            out_valid <= ev.strobe;
            if (ev.strobe) begin
                out_data <= chosen;
                if (!bad) last_good <= smp_data;
            end
        end
    end

endmodule

// File: rtl/rx_err_logger.sv
module rx_err_logger
    import rxel_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [6:0]        err_flags,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              irq,
    output logic              rerr,
    output logic              nverr
);

    logic [NERR-1:0] mask_q;
    logic [NERR-1:0] status_q;
    hold_e           hold_q;
    err_ev_t         ev;

    assign ev.strobe = smp_valid;
    assign ev.live   = smp_valid ? (err_flags & mask_q) : '0;

    rxel_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .ev        (ev),
        .mask_q    (mask_q),
        .hold_q    (hold_q),
        .status_q  (status_q),
        .reg_rdata (reg_rdata)
    );

    rxel_level u_level (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .irq   (irq),
        .rerr  (rerr),
        .nverr (nverr)
    );

    rxel_conceal #(.DATA_W(DATA_W)) u_conceal (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .smp_data  (smp_data),
        .hold_q    (hold_q),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/rxel_chk.sv
module rxel_chk
    import rxel_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_valid,
    input logic [DATA_W-1:0] smp_data,
    input logic [6:0]        err_flags,
    input logic [6:0]        mask_q,
    input logic [1:0]        hold_q,
    input logic [6:0]        status_q,
    input logic              reg_rd,
    input logic [1:0]        reg_addr,
    input logic              irq,
    input logic              rerr,
    input logic              nverr,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    p_level_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(rerr) && $stable(nverr));

    p_nverr_subset_r7: assert property (@(posedge clk) disable iff (rst)
        nverr |-> rerr);

    p_irq_cause_r5: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(smp_valid));

    p_masked_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        smp_valid && ((err_flags & mask_q) == 7'd0) |=> !irq && !rerr && !nverr);

    p_crc_no_touch_r11: assert property (@(posedge clk) disable iff (rst)
        smp_valid && ((err_flags & mask_q & SAMPLE_AFFECT) == 7'd0)
        |=> out_valid && (out_data == $past(smp_data)));

    p_mute_zero_r9: assert property (@(posedge clk) disable iff (rst)
        smp_valid && (hold_q == 2'b01) && ((err_flags & mask_q & SAMPLE_AFFECT) != 7'd0)
        |=> out_data == '0);

    p_read_clears_r3: assert property (@(posedge clk) disable iff (rst)
        reg_rd && (reg_addr == ADDR_STAT) && !smp_valid |=> status_q == 7'd0);

    p_sticky_keep_r12: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> ((status_q & $past(err_flags & mask_q)) == $past(err_flags & mask_q)));

    p_out_strobe_r13: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> out_valid);

endmodule

bind rx_err_logger rxel_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .err_flags (err_flags),
    .mask_q    (mask_q),
    .hold_q    (hold_q),
    .status_q  (status_q),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .irq       (irq),
    .rerr      (rerr),
    .nverr     (nverr),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/test_rx_err_logger.sv
module test_rx_err_logger;

    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic [6:0]    err_flags = '0;
    logic [1:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          irq, rerr, nverr;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    rx_err_logger #(.DATA_W(DW)) i_rx_err_logger (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .err_flags(err_flags), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .out_valid(out_valid), .out_data(out_data), .irq(irq),
        .rerr(rerr), .nverr(nverr)
    );

    typedef struct packed {
        logic [1:0]    mode;
        logic [7:0]    mask;
        logic [6:0]    flags;
        logic [DW-1:0] din;
        logic [DW-1:0] dout;
        logic          r;
        logic          n;
        logic          i;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'h7F, 7'h00, 24'h111111, 24'h111111, 1'b0, 1'b0, 1'b0},
        '{2'd0, 8'h7F, 7'h02, 24'h222222, 24'h111111, 1'b1, 1'b1, 1'b1},
        '{2'd0, 8'h7F, 7'h01, 24'h333333, 24'h111111, 1'b1, 1'b0, 1'b1},
        '{2'd1, 8'h7F, 7'h04, 24'h444444, 24'h000000, 1'b1, 1'b1, 1'b1},
        '{2'd2, 8'h7F, 7'h08, 24'h555555, 24'h555555, 1'b1, 1'b1, 1'b1},
        '{2'd3, 8'h7F, 7'h10, 24'h666666, 24'h666666, 1'b1, 1'b1, 1'b1},
        '{2'd0, 8'h7F, 7'h60, 24'h777777, 24'h777777, 1'b1, 1'b1, 1'b1},
        '{2'd0, 8'h7F, 7'h02, 24'h888888, 24'h777777, 1'b1, 1'b1, 1'b1},
        '{2'd0, 8'h7D, 7'h02, 24'h999999, 24'h999999, 1'b0, 1'b0, 1'b0},
        '{2'd1, 8'h00, 7'h7F, 24'hABCDEF, 24'hABCDEF, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic push(input logic [6:0] f, input logic [DW-1:0] d);
        @(negedge clk);
        smp_valid = 1'b1; err_flags = f; smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0; err_flags = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 out_valid", out_valid, 0);
        chk("R1 out_data", out_data, 0);
        chk("R1 irq/rerr/nverr", {irq, rerr, nverr}, 0);
        reg_read(2'd0, rd); chk("R1 mask", rd, 8'h00);
        reg_read(2'd1, rd); chk("R1 status", rd, 8'h00);
        reg_read(2'd2, rd); chk("R1 hold", rd, 8'h00);

        // R8 repeat before any clean sample gives zero
        reg_write(2'd0, 8'h02);
        push(7'h02, 24'h0F0F0F);
        chk("R8 repeat initial zero", out_data, 24'h0);
        chk("R13 out_valid", out_valid, 1);
        @(negedge clk);
        chk("R13 out_valid drops", out_valid, 0);
        chk("R5 irq single cycle", irq, 0);
        reg_read(2'd1, rd);

        // R2 write 0xFF to mask reads back 0x7F, policy field width
        reg_write(2'd0, 8'hFF);
        reg_read(2'd0, rd); chk("R2 mask bit7 zero", rd, 8'h7F);
        reg_write(2'd2, 8'hFF);
        reg_read(2'd2, rd); chk("R2 hold field", rd, 8'h03);
        reg_read(2'd3, rd); chk("R2 unused address", rd, 8'h00);

        // vector table
        for (int k = 0; k < NV; k++) begin
            reg_write(2'd2, {6'b0, VEC[k].mode});
            reg_write(2'd0, VEC[k].mask);
            push(VEC[k].flags, VEC[k].din);
            chk("R8/R9/R10/R11 out_data", out_data, VEC[k].dout);
            chk("R6 rerr", rerr, VEC[k].r);
            chk("R7 nverr", nverr, VEC[k].n);
            chk("R5 irq", irq, VEC[k].i);
            reg_read(2'd1, rd);
            chk("R3/R4 status", rd, {1'b0, VEC[k].flags & VEC[k].mask[6:0]});
        end

        // R3 sticky accumulation, then clear on read
        reg_write(2'd0, 8'h7F);
        reg_write(2'd2, 8'h02);
        push(7'h04, 24'h1);
        push(7'h00, 24'h2);
        push(7'h20, 24'h3);
        reg_read(2'd1, rd); chk("R3 sticky OR", rd, 8'h24);
        reg_read(2'd1, rd); chk("R3 cleared after read", rd, 8'h00);

        // R6 level held between strobes and unaffected by read
        push(7'h08, 24'h4);
        repeat (3) @(negedge clk);
        chk("R6 rerr held idle", rerr, 1);
        reg_read(2'd1, rd);
        chk("R6 rerr after read", rerr, 1);
        chk("R7 nverr after read", nverr, 1);
        push(7'h00, 24'h5);
        chk("R6 rerr clears on clean sample", rerr, 0);

        // R12 read coincident with new error
        push(7'h10, 24'h6);
        @(negedge clk);
        reg_addr = 2'd1; reg_rd = 1'b1;
        smp_valid = 1'b1; err_flags = 7'h02; smp_data = 24'h7;
        @(negedge clk);
        reg_rd = 1'b0; smp_valid = 1'b0; err_flags = '0;
        chk("R12 read returns old", reg_rdata, 8'h10);
        reg_read(2'd1, rd); chk("R12 new error kept", rd, 8'h02);

        // R4 masked single flag leaves status and outputs alone
        reg_write(2'd0, 8'h7E);
        push(7'h01, 24'h8);
        chk("R4 masked validity rerr", rerr, 0);
        chk("R4 masked validity irq", irq, 0);
        reg_read(2'd1, rd); chk("R4 masked validity status", rd, 8'h00);

        finish_run();
    end

endmodule